// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped line store with a small fully associative victim buffer beside it. Each lookup searches both. A hit in the direct-mapped set answers at once. A hit that is found only in the victim buffer exchanges that line with the line that occupies the conflicting set. A miss in both raises a refill request to memory. A line can live in the direct-mapped array or in the buffer, but never in both. The buffer therefore adds a little associativity to the sets that conflict, and the direct-mapped path stays fast.

A client sends one whole-line read or write through the request port and then waits for a response pulse. The response says where the line was found. When a refill pushes a valid line out of the direct-mapped set, that line moves into the buffer. The buffer fills a free slot first. When it has no free slot, it replaces its least recently used entry. A dirty line that leaves the buffer is written back to memory, and a clean one is discarded. Line width, address width, set count and buffer depth are parameters. The design also works when the buffer has only one entry.

Top module: `victim_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, mem_rd_valid and wb_valid are 0, and no line is held, so the first access to any address misses in both structures.
- R2: An accepted request whose line is in the direct-mapped set gives resp_valid in the next cycle with resp_src = 2'b01 and the line contents in resp_data.
- R3: An accepted request whose line is found only in the victim buffer gives resp_valid two cycles after acceptance with resp_src = 2'b10. The line moves into its direct-mapped set, and the line displaced from that set takes the freed buffer entry.
- R4: req_ready is 0 during the swap cycle and while a refill is outstanding. A req_valid asserted in those cycles is ignored.
- R5: On a miss in both structures, mem_rd_valid is held with mem_rd_addr equal to the request address until mem_fill_valid. In the cycle after the fill, resp_valid pulses with resp_src = 2'b11, and the fill data is placed in the direct-mapped set.
- R6: The valid line evicted by a refill enters the victim buffer. If this pushes out a dirty buffer line, wb_valid pulses for one cycle with that line's address and data. A clean line that is pushed out is dropped with no writeback.
- R7: A line entering the buffer takes a free entry if one exists and otherwise the least recently used entry. An entry written by a swap or by an allocation becomes the most recently used.
- R8: All of the behaviour above holds with a single victim entry.
- R9: A write replaces the whole line with req_wdata and marks it dirty. The dirty mark stays with the line when it moves between the two structures. resp_data returns the line contents after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write the whole line, 0 = read |
| req_addr | input | ADDR_W | Line address; the low IDX_W bits select the set |
| req_wdata | input | LINE_W | Write line data |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_src | output | 2 | 01 direct-mapped hit, 10 victim hit, 11 refilled from memory |
| resp_data | output | LINE_W | Line contents after the access |
| mem_rd_valid | output | 1 | Refill request outstanding |
| mem_rd_addr | output | ADDR_W | Address to refill |
| mem_fill_valid | input | 1 | Refill data present |
| mem_fill_data | input | LINE_W | Refill line |
| wb_valid | output | 1 | One-cycle writeback pulse |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
A directed sequence first runs four cases on a single set: a miss, a repeated hit, a write hit, and a pair of lines that ping-pong between the set and the buffer. Together these separate a direct-mapped hit from a swap and from a refill. A random phase then uses up to eight tags on two sets with mixed reads and writes. This keeps the buffer full, so least-recently-used replacement of dirty and clean lines is exercised, and the bench can see wrong victim choices through writeback addresses and later hit sources. Requests are also driven while the block is stalled, and refill latency is random, to show that those requests are ignored and the refill request is held. Both phases run with a four-entry buffer and with a one-entry buffer.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_FILL = 2'd2
  } vc_state_e;

  localparam logic [1:0] SRC_NONE = 2'b00;
  localparam logic [1:0] SRC_MAIN = 2'b01;
  localparam logic [1:0] SRC_VICT = 2'b10;
  localparam logic [1:0] SRC_MEM  = 2'b11;

  // index/age width for n entries (at least one bit)
  function automatic int sel_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // recency age after an entry whose age is touched_age becomes newest
  function automatic int age_after(int cur, int touched_age, bit is_touched);
    if (is_touched) return 0;
    return (cur < touched_age) ? cur + 1 : cur;
  endfunction

  // line value after an access: whole-line write or keep
  function automatic logic [1023:0] line_after(bit we, logic [1023:0] wdata,
                                               logic [1023:0] old);
    return we ? wdata : old;
  endfunction
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              wr_dirty
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf
  import vc_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 12,
  parameter int LINE_W = 32,
  localparam int SW    = sel_bits(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [SW-1:0]     hit_idx,
  output logic [LINE_W-1:0] hit_data,
  output logic              hit_dirty,
  output logic [SW-1:0]     rep_idx,
  output logic              rep_valid,
  output logic [ADDR_W-1:0] rep_addr,
  output logic [LINE_W-1:0] rep_data,
  output logic              rep_dirty,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              wr_dirty
);
  logic [N-1:0]      v_q;
  logic [N-1:0]      d_q;
  logic [ADDR_W-1:0] a_q   [N];
  logic [LINE_W-1:0] dat_q [N];
  logic [SW-1:0]     age_q [N];
  logic [N-1:0]      match;
  logic              have_free;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = v_q[g] && (a_q[g] == lk_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = SW'(i);
    end
  end

  assign hit       = |match;
  assign hit_data  = dat_q[hit_idx];
  assign hit_dirty = d_q[hit_idx];

  // free slot first, else oldest entry
  always_comb begin
    rep_idx   = '0;
    have_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!v_q[i] && !have_free) begin
        rep_idx   = SW'(i);
        have_free = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < N; i++) begin
        if (int'(age_q[i]) == N - 1) rep_idx = SW'(i);
      end
    end
  end

  assign rep_valid = v_q[rep_idx];
  assign rep_dirty = d_q[rep_idx];
  assign rep_addr  = a_q[rep_idx];
  assign rep_data  = dat_q[rep_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= SW'(i);
    end else if (wr_en) begin
      v_q[wr_idx] <= wr_valid;
      d_q[wr_idx] <= wr_dirty;
      for (int i = 0; i < N; i++) begin
        age_q[i] <= SW'(age_after(int'(age_q[i]), int'(age_q[wr_idx]),
                                  SW'(i) == wr_idx));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      a_q[wr_idx]   <= wr_addr;
      dat_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int LINE_W = 32,
  parameter int VICT_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [1:0]        resp_src,
  output logic [LINE_W-1:0] resp_data,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_fill_valid,
  input  logic [LINE_W-1:0] mem_fill_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SW    = sel_bits(VICT_N);

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction
  function automatic logic [LINE_W-1:0] pick(bit we, logic [LINE_W-1:0] w,
                                             logic [LINE_W-1:0] old);
    return LINE_W'(line_after(we, 1024'(w), 1024'(old)));
  endfunction

  vc_state_e         state_q;
  logic [ADDR_W-1:0] p_addr;
  logic              p_we;
  logic [LINE_W-1:0] p_wdata;
  logic [ADDR_W-1:0] cur_addr;

  logic              m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_data;
  logic              m_hit;

  logic              v_hit, v_hit_dirty, rep_valid, rep_dirty;
  logic [SW-1:0]     v_hit_idx, rep_idx;
  logic [LINE_W-1:0] v_hit_data, rep_data;
  logic [ADDR_W-1:0] rep_addr;

  // named internal events
  logic ev_accept, ev_main_hit, ev_vict_hit, ev_miss, ev_swap, ev_fill, ev_evict, ev_wb;

  logic              mw_en, mw_dirty;
  logic [LINE_W-1:0] mw_data;
  logic              vw_en;
  logic [SW-1:0]     vw_idx;

  assign cur_addr = (state_q == ST_IDLE) ? req_addr : p_addr;
  assign m_hit    = m_valid && (m_tag == tag_of(cur_addr));

  assign ev_accept   = req_valid && (state_q == ST_IDLE);
  assign ev_main_hit = ev_accept && m_hit;
  assign ev_vict_hit = ev_accept && !m_hit && v_hit;
  assign ev_miss     = ev_accept && !m_hit && !v_hit;
  assign ev_swap     = (state_q == ST_SWAP);
  assign ev_fill     = (state_q == ST_FILL) && mem_fill_valid;
  assign ev_evict    = ev_fill && m_valid;
  assign ev_wb       = ev_evict && rep_valid && rep_dirty;

  always_comb begin
    mw_en    = (ev_main_hit && req_we) || ev_swap || ev_fill;
    mw_data  = req_wdata;
    mw_dirty = 1'b1;
    if (ev_swap) begin
      mw_data  = pick(p_we, p_wdata, v_hit_data);
      mw_dirty = p_we || v_hit_dirty;
    end else if (ev_fill) begin
      mw_data  = pick(p_we, p_wdata, mem_fill_data);
      mw_dirty = p_we;
    end
  end

  assign vw_en  = ev_swap || ev_evict;
  assign vw_idx = ev_swap ? v_hit_idx : rep_idx;

  vc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx_of(cur_addr)), .rd_valid(m_valid), .rd_tag(m_tag),
    .rd_data(m_data), .rd_dirty(m_dirty),
    .wr_en(mw_en), .wr_idx(idx_of(cur_addr)), .wr_tag(tag_of(cur_addr)),
    .wr_data(mw_data), .wr_dirty(mw_dirty)
  );

  vc_victim_buf #(.N(VICT_N), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_vbuf (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(cur_addr), .hit(v_hit), .hit_idx(v_hit_idx),
    .hit_data(v_hit_data), .hit_dirty(v_hit_dirty),
    .rep_idx(rep_idx), .rep_valid(rep_valid), .rep_addr(rep_addr),
    .rep_data(rep_data), .rep_dirty(rep_dirty),
    .wr_en(vw_en), .wr_idx(vw_idx), .wr_valid(m_valid),
    .wr_addr({m_tag, idx_of(cur_addr)}), .wr_data(m_data), .wr_dirty(m_dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      p_addr     <= '0;
      p_we       <= 1'b0;
      p_wdata    <= '0;
      resp_valid <= 1'b0;
      resp_src   <= SRC_NONE;
      resp_data  <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      resp_valid <= ev_main_hit || ev_swap || ev_fill;
      resp_src   <= ev_main_hit ? SRC_MAIN : ev_swap ? SRC_VICT :
                    ev_fill ? SRC_MEM : SRC_NONE;
      if (ev_main_hit) resp_data <= pick(req_we, req_wdata, m_data);
      else if (ev_swap || ev_fill) resp_data <= mw_data;
      wb_valid <= ev_wb;
      if (ev_wb) begin
        wb_addr <= rep_addr;
        wb_data <= rep_data;
      end
      if (ev_vict_hit || ev_miss) begin
        p_addr  <= req_addr;
        p_we    <= req_we;
        p_wdata <= req_wdata;
        state_q <= ev_vict_hit ? ST_SWAP : ST_FILL;
      end else if (ev_swap || ev_fill) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_FILL);
  assign mem_rd_addr  = p_addr;
endmodule

// File: rtl/victim_cache_chk.sv
module victim_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ev_main_hit,
  input logic              ev_vict_hit,
  input logic              ev_swap,
  input logic              resp_valid,
  input logic [1:0]        resp_src,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_fill_valid,
  input logic              wb_valid
);
  assert_main_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_main_hit |=> resp_valid && resp_src == 2'b01);

  assert_vhit_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vict_hit |=> !req_ready && !resp_valid);

  assert_swap_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> resp_valid && resp_src == 2'b10 && req_ready);

  assert_refill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_fill_valid |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_refill_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_fill_valid |=> resp_valid && resp_src == 2'b11 && !mem_rd_valid);

  assert_wb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
endmodule

bind victim_cache victim_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .ev_main_hit(ev_main_hit), .ev_vict_hit(ev_vict_hit), .ev_swap(ev_swap),
  .resp_valid(resp_valid), .resp_src(resp_src),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_fill_valid(mem_fill_valid), .wb_valid(wb_valid)
);

// File: tb/victim_cache_bench.sv
module victim_cache_lane #(
  parameter int VICT_N = 4
) (
  input  logic clk,
  output int   errs,
  output int   checks,
  output logic done
);
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int LINE_W = 32;
  localparam int SETS   = 1 << IDX_W;

  logic              rst_n, req_valid, req_we, req_ready, resp_valid;
  logic [ADDR_W-1:0] req_addr, mem_rd_addr, wb_addr;
  logic [LINE_W-1:0] req_wdata, resp_data, mem_fill_data, wb_data;
  logic [1:0]        resp_src;
  logic              mem_rd_valid, mem_fill_valid, wb_valid;

  victim_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .VICT_N(VICT_N))
  u_victim_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_src(resp_src), .resp_data(resp_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  typedef struct {
    int unsigned a;
    logic [31:0] d;
    bit          dirty;
  } line_t;

  // behavioural model: recency-ordered queue (front = newest), per-set arrays
  line_t       vq[$];
  bit          mv[SETS];
  int unsigned mt[SETS];
  logic [31:0] md[SETS];
  bit          mdy[SETS];
  logic [31:0] mem[int unsigned];
  int          m_state;
  int unsigned p_addr;
  bit          p_we;
  logic [31:0] p_wdata;
  int          lat;

  bit          x_resp, x_wb, x_we;
  int          x_src;
  logic [31:0] x_data, x_wbd;
  int unsigned x_wba;

  function automatic logic [31:0] mem_val(int unsigned a);
    if (mem.exists(a)) return mem[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic int find_v(int unsigned a);
    foreach (vq[i]) if (vq[i].a == a) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s (victim entries=%0d%s) %s: act=%h exp=%h", tag, VICT_N,
               VICT_N == 1 ? ", R8" : "", what, act, exp);
    end
  endtask

  task automatic model_edge();
    int idx, k;
    int unsigned tg;
    line_t e, t, dsp;
    x_resp = 0; x_wb = 0; x_src = 0;
    case (m_state)
      0: if (req_valid) begin
        idx = int'(req_addr) % SETS; tg = int'(req_addr) / SETS;
        if (mv[idx] && mt[idx] == tg) begin
          if (req_we) begin md[idx] = req_wdata; mdy[idx] = 1; end
          x_resp = 1; x_src = 1; x_data = md[idx]; x_we = req_we;
        end else begin
          p_addr = req_addr; p_we = req_we; p_wdata = req_wdata;
          m_state = (find_v(req_addr) >= 0) ? 1 : 2;
          lat = $urandom_range(0, 3);
        end
      end
      1: begin
        idx = p_addr % SETS; tg = p_addr / SETS;
        k = find_v(p_addr);
        e = vq[k];
        vq.delete(k);
        if (mv[idx]) begin
          dsp.a = mt[idx] * SETS + idx; dsp.d = md[idx]; dsp.dirty = mdy[idx];
          vq.push_front(dsp);
        end
        mv[idx] = 1; mt[idx] = tg;
        md[idx] = p_we ? p_wdata : e.d;
        mdy[idx] = p_we || e.dirty;
        x_resp = 1; x_src = 2; x_data = md[idx]; x_we = p_we;
        m_state = 0;
      end
      default: if (mem_fill_valid) begin
        idx = p_addr % SETS; tg = p_addr / SETS;
        if (mv[idx]) begin
          if (vq.size() == VICT_N) begin
            t = vq.pop_back();  // least recently used leaves (R7)
            if (t.dirty) begin
              x_wb = 1; x_wba = t.a; x_wbd = t.d; mem[t.a] = t.d;
            end
          end
          dsp.a = mt[idx] * SETS + idx; dsp.d = md[idx]; dsp.dirty = mdy[idx];
          vq.push_front(dsp);
        end
        mv[idx] = 1; mt[idx] = tg;
        md[idx] = p_we ? p_wdata : mem_fill_data;
        mdy[idx] = p_we;
        x_resp = 1; x_src = 3; x_data = md[idx]; x_we = p_we;
        m_state = 0;
      end
    endcase
  endtask

  task automatic compare(bit first);
    string rt, st;
    rt = first ? "R1" : "R4";
    chk(rt, "req_ready", 32'(req_ready), 32'(m_state == 0));
    chk(first ? "R1" : "R5", "mem_rd_valid", 32'(mem_rd_valid), 32'(m_state == 2));
    if (m_state == 2) chk("R5", "mem_rd_addr", 32'(mem_rd_addr), p_addr);
    st = (x_src == 1) ? "R2" : (x_src == 2) ? "R3" : "R5";
    chk(first ? "R1" : st, "resp_valid", 32'(resp_valid), 32'(x_resp));
    if (x_resp) begin
      chk(st, "resp_src", 32'(resp_src), 32'(x_src));
      chk(x_we ? "R9" : st, "resp_data", resp_data, x_data);
    end
    chk(first ? "R1" : "R6 R7", "wb_valid", 32'(wb_valid), 32'(x_wb));
    if (x_wb) begin
      chk("R6 R7", "wb_addr", 32'(wb_addr), x_wba);
      chk("R6", "wb_data", wb_data, x_wbd);
    end
  endtask

  initial begin
    int unsigned dir[$];
    errs = 0; checks = 0; done = 0;
    m_state = 0; x_resp = 0; x_wb = 0; x_src = 0;
    foreach (mv[i]) begin mv[i] = 0; mdy[i] = 0; end
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    mem_fill_valid = 0; mem_fill_data = '0;
    // directed: miss, hit, write hit, ping-pong in set 0, then conflict chain
    dir = '{32'h010, 32'h010, 32'h1010, 32'h020, 32'h010, 32'h020,
            32'h030, 32'h040, 32'h050, 32'h060, 32'h070, 32'h010};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      compare(cyc == 0);
      if (m_state == 2 && lat == 0) begin
        mem_fill_valid = 1; mem_fill_data = mem_val(p_addr);
      end else begin
        if (m_state == 2) lat--;
        mem_fill_valid = 0; mem_fill_data = $urandom;
      end
      req_wdata = $urandom;
      if (m_state == 0 && dir.size() > 0) begin
        req_valid = 1;
        req_we = dir[0][12];
        req_addr = ADDR_W'(dir[0]);
        void'(dir.pop_front());
      end else begin
        req_valid = ($urandom_range(0, 3) != 0);
        req_we = ($urandom_range(0, 9) < 3);
        req_addr = ADDR_W'($urandom_range(0, 7) * SETS + $urandom_range(0, 1));
      end
      model_edge();
    end
    @(negedge clk);
    compare(0);
    done = 1;
  end
endmodule

module victim_cache_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int   e4, c4, e1, c1;
  logic d4, d1;

  victim_cache_lane #(.VICT_N(4)) u_lane4 (.clk(clk), .errs(e4), .checks(c4), .done(d4));
  victim_cache_lane #(.VICT_N(1)) u_lane1 (.clk(clk), .errs(e1), .checks(c1), .done(d1));

  initial begin
    int n;
    int te, tc;
    n = 0;
    while (!(d4 === 1'b1 && d1 === 1'b1) && n < 100000) begin
      @(posedge clk);
      n++;
    end
    #1;
    te = e4 + e1;
    tc = c4 + c1;
    if (!(d4 === 1'b1 && d1 === 1'b1)) begin
      te++; tc++;
      $display("FAIL watchdog: run did not complete, act=%0d exp=<%0d cycles", n, 100000);
    end
    $display("Result: errors=%0d of %0d checks", te, tc);
    $finish;
  end
endmodule